// File: doc/BRIEF.md
# Proximity Link Frame Codec

This block turns byte buffers into bit-level frames for a 106 kbit/s proximity-card link, and turns received bit streams back into bytes. Each frame opens with a single start bit. Data follows byte by byte, least-significant bit first and lowest buffer address first. An odd parity bit follows every byte. The transmitter can add a 16-bit CRC to the end of the data. It also has a short mode that sends seven bits with no parity and no CRC.

The receiver takes one bit per accepted strike and rebuilds the bytes into a buffer that can be read back. When the line decoder signals the end of the frame, the receiver checks parity, bit count and CRC and raises a separate flag for each fault. Line coding and carrier modulation are done outside this block. Both directions share a single bit-enable strobe, and a bit moves on each strike.

Top module: `prox_frame_codec`

## Requirements
- R1: After reset, tx_active, tx_bit, tx_done, rx_done, parity_err, crc_err and length_err are all 0, and rx_nbytes is 0.
- R2: After a tx_start pulse while idle, tx_active rises on the next cycle and tx_bit presents the start bit (value 1). Each bit_stb strike then advances tx_bit through the bytes, lowest address first and each byte least-significant bit first.
- R3: A transmitted normal frame carries, after the eighth bit of every byte, one parity bit that makes the count of ones in those nine bits odd.
- R4: With tx_crc_on set and tx_short clear, two bytes follow the data. They hold a CRC over all data bits, taken least-significant bit first, with reflected polynomial x^16+x^12+x^5+1 and seed 0x6363 and no final inversion. The low byte goes first, and each CRC byte gets its own parity bit. For data bytes 0x50, 0x00 the CRC bytes are 0x57 then 0xCD.
- R5: With tx_short set, a frame is the start bit followed by bits 0 to 6 of buffer entry 0: eight bits in all, with no parity and no CRC.
- R6: tx_done is high for exactly one cycle: the cycle after the strike that takes the final bit. tx_active falls in that same cycle. A tx_start while tx_active is high has no effect on the frame or on what follows it.
- R7: The transmitted data byte count is tx_nbytes clamped: 0 means 1, and the upper limit is 16 with CRC and 18 without.
- R8: The receiver takes rx_bit on each cycle with bit_stb and rx_valid high. It treats the first bit as the start bit and stores each completed byte at the next buffer address, including CRC bytes, up to 18 entries. The cycle after rx_end, rx_done pulses and rx_nbytes gives the stored byte count. rx_rd_data shows entry rx_rd_addr combinationally.
- R9: parity_err is set when any received byte's parity bit does not give odd parity over its nine bits.
- R10: length_err is set unless the bit count is 8 (a short frame, stored in entry 0 bits 6:0 with bit 7 zero, count 1), or is 1+9·n with n at least 1 and at most 163 bits.
- R11: With rx_crc_on set, crc_err is set when a frame of valid length is not short and either holds fewer than 3 bytes or does not leave a zero CRC remainder over all its bytes. crc_err is never set alongside length_err.
- R12: rx_done is a one-cycle pulse. The error flags and rx_nbytes keep their values until the next rx_end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_stb | input | 1 | Bit-enable strike shared by both directions |
| tx_wr_en | input | 1 | Write strobe for the transmit buffer |
| tx_wr_addr | input | 5 | Transmit buffer write address |
| tx_wr_data | input | 8 | Transmit buffer write byte |
| tx_start | input | 1 | Begin a frame (ignored while active) |
| tx_nbytes | input | 5 | Requested data byte count |
| tx_crc_on | input | 1 | Append CRC to the frame |
| tx_short | input | 1 | Send a seven-bit short frame |
| tx_bit | output | 1 | Current transmit bit |
| tx_active | output | 1 | A frame is being sent |
| tx_done | output | 1 | One-cycle end-of-frame pulse |
| rx_bit | input | 1 | Received bit |
| rx_valid | input | 1 | Qualifies rx_bit on a strike |
| rx_end | input | 1 | End of the received frame |
| rx_crc_on | input | 1 | Frame carries a CRC to check |
| rx_rd_addr | input | 5 | Receive buffer read address |
| rx_rd_data | output | 8 | Receive buffer byte |
| rx_nbytes | output | 5 | Bytes stored from the last frame |
| rx_done | output | 1 | One-cycle frame-checked pulse |
| parity_err | output | 1 | Parity fault in the last frame |
| crc_err | output | 1 | CRC fault in the last frame |
| length_err | output | 1 | Bit-count fault in the last frame |

## Verification
tx_bit is combinational from registered state, so it is compared in the cycle the bench applies each strike. The next bit is due one clock edge after that strike. tx_done and the fall of tx_active appear exactly one edge after the final strike, and the next cycle is checked again for the pulse's end. Receive flags, rx_done and rx_nbytes are registered from rx_end, so the bench samples them at the falling edge after the edge that took rx_end. Buffer contents are read combinationally a short delay after the address is set. All inputs change and all outputs are sampled on falling edges, away from the edge that updates state.

// File: rtl/prox_codec_pkg.sv
// Shared constants and helpers for the proximity frame codec.
// Assumes: CRC is processed one bit at a time, least-significant bit first.
package prox_codec_pkg;

    localparam logic [15:0] CRC_SEED = 16'h6363;
    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
    localparam logic        START_BIT_VAL = 1'b1;

    // One reflected CRC step for a single input bit.
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        crc_step = (c >> 1) ^ (fb ? CRC_POLY_REFL : 16'h0000);
    endfunction

    // Parity bit that makes a byte plus its parity hold an odd count of ones.
    function automatic logic odd_parity(input logic [7:0] d);
        odd_parity = ~^d;
    endfunction

endpackage

// File: rtl/prox_crc16.sv
// Bit-serial 16-bit CRC register.
// Assumes: init and step are not asserted together; init takes priority.
module prox_crc16
    import prox_codec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        step,
    input  logic        din,
    output logic [15:0] crc
);

    // Seed on init, advance by one bit on step, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc <= CRC_SEED;
        end else if (init) begin
            crc <= CRC_SEED;
        end else if (step) begin
            crc <= crc_step(crc, din);
        end
    end

    p_crc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !step) |=> $stable(crc));

    p_crc_seed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (crc == CRC_SEED));

endmodule

// File: rtl/prox_tx_serializer.sv
// Frame serializer: start bit, LSB-first bytes with odd parity, optional CRC
// tail, or a seven-bit short frame. One bit is consumed per bit_stb strike.
// Assumes: the buffer is not rewritten while a frame is being sent.
module prox_tx_serializer
    import prox_codec_pkg::*;
#(
    parameter int MAX_DATA = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_stb,
    input  logic          wr_en,
    input  logic [$clog2(MAX_DATA+2)-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          start,
    input  logic [$clog2(MAX_DATA+3)-1:0] nbytes,
    input  logic          crc_on,
    input  logic          short_mode,
    output logic          tx_bit,
    output logic          active,
    output logic          done
);

    localparam int DEPTH = MAX_DATA + 2;
    localparam int AW    = $clog2(DEPTH);
    localparam int NW    = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic          at_start;
    logic          short_q;
    logic          crc_q;
    logic [NW-1:0] len_q;
    logic [NW-1:0] total_q;
    logic [NW-1:0] byte_idx;
    logic [3:0]    bit_idx;
    logic [NW-1:0] cap;
    logic [NW-1:0] eff_len;
    logic [7:0]    cur_byte;
    logic          last_bit;
    logic          crc_step_en;
    logic [15:0]   crc_val;

    // Buffer write port; out-of-range addresses are dropped.
    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Clamp the requested byte count to what fits in one frame.
    always_comb begin
        cap     = crc_on ? NW'(MAX_DATA) : NW'(DEPTH);
        eff_len = (nbytes == '0) ? NW'(1) : ((nbytes > cap) ? cap : nbytes);
    end

    // Select the byte on the line: data, then CRC low, then CRC high.
    always_comb begin
        if (byte_idx < len_q) begin
            cur_byte = mem[byte_idx[AW-1:0]];
        end else if (byte_idx == len_q) begin
            cur_byte = crc_val[7:0];
        end else begin
            cur_byte = crc_val[15:8];
        end
    end

    // Current line bit and end-of-frame detection.
    always_comb begin
        if (!active) begin
            tx_bit = 1'b0;
        end else if (at_start) begin
            tx_bit = START_BIT_VAL;
        end else if (bit_idx < 4'd8) begin
            tx_bit = cur_byte[bit_idx[2:0]];
        end else begin
            tx_bit = odd_parity(cur_byte);
        end
        if (at_start) begin
            last_bit = 1'b0;
        end else if (short_q) begin
            last_bit = (bit_idx == 4'd6);
        end else begin
            last_bit = (bit_idx == 4'd8) && (byte_idx == total_q - NW'(1));
        end
    end

    // CRC advances only on data bits of a normal frame.
    assign crc_step_en = active && bit_stb && !at_start && !short_q &&
                         (bit_idx < 4'd8) && (byte_idx < len_q);

    prox_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (!active && start),
        .step  (crc_step_en),
        .din   (tx_bit),
        .crc   (crc_val)
    );

    // Frame sequencer: latch settings at start, step position per strike.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            done     <= 1'b0;
            at_start <= 1'b0;
            short_q  <= 1'b0;
            crc_q    <= 1'b0;
            len_q    <= '0;
            total_q  <= '0;
            byte_idx <= '0;
            bit_idx  <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active   <= 1'b1;
                    at_start <= 1'b1;
                    short_q  <= short_mode;
                    crc_q    <= crc_on && !short_mode;
                    len_q    <= short_mode ? NW'(1) : eff_len;
                    total_q  <= short_mode ? NW'(1) :
                                (eff_len + ((crc_on) ? NW'(2) : NW'(0)));
                    byte_idx <= '0;
                    bit_idx  <= '0;
                end
            end else if (bit_stb) begin
                if (last_bit) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else if (at_start) begin
                    at_start <= 1'b0;
                end else if (!short_q && (bit_idx == 4'd8)) begin
                    bit_idx  <= '0;
                    byte_idx <= byte_idx + NW'(1);
                end else begin
                    bit_idx <= bit_idx + 4'd1;
                end
            end
        end
    end

    p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (tx_bit == START_BIT_VAL));

    p_hold_no_strike_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bit_stb) |=> (active && $stable(bit_idx) && $stable(byte_idx)));

    p_bit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (bit_idx <= 4'd8));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !active);

    p_last_then_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bit_stb && last_bit) |=> (done && !active));

    p_len_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ((len_q >= NW'(1)) && (total_q <= NW'(DEPTH)) && (crc_q || total_q == len_q)));

endmodule

// File: rtl/prox_rx_deserializer.sv
// Frame deserializer: takes one bit per accepted strike, rebuilds bytes into a
// buffer and, at end of frame, checks parity, bit count and CRC remainder.
// Assumes: end_in never coincides with an accepted bit.
module prox_rx_deserializer
    import prox_codec_pkg::*;
#(
    parameter int MAX_DATA = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          bit_in,
    input  logic          end_in,
    input  logic          crc_on,
    input  logic [$clog2(MAX_DATA+2)-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [$clog2(MAX_DATA+3)-1:0] nbytes,
    output logic          done,
    output logic          parity_err,
    output logic          crc_err,
    output logic          length_err
);

    localparam int DEPTH    = MAX_DATA + 2;
    localparam int AW       = $clog2(DEPTH);
    localparam int NW       = $clog2(DEPTH + 1);
    localparam int MAX_BITS = 1 + 9 * DEPTH;
    localparam int CW       = $clog2(MAX_BITS + 1) + 1;
    localparam int MIN_CRC_BYTES = 3;

    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [3:0]    bit_idx;
    logic [NW-1:0] byte_idx;
    logic [7:0]    sh;
    logic          par_bad;
    logic          take;
    logic          is_short;
    logic          len_ok;
    logic          crc_bad;
    logic [15:0]   crc_val;

    assign take = stb && !end_in;

    prox_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (take && (cnt == '0)),
        .step  (take && (cnt != '0) && (bit_idx < 4'd8)),
        .din   (bit_in),
        .crc   (crc_val)
    );

    // End-of-frame verdicts from the position counters and CRC remainder.
    always_comb begin
        is_short = (cnt == CW'(8));
        len_ok   = is_short ||
                   ((cnt <= CW'(MAX_BITS)) && (bit_idx == 4'd0) && (byte_idx != '0));
        crc_bad  = crc_on && !is_short && len_ok &&
                   ((byte_idx < NW'(MIN_CRC_BYTES)) || (crc_val != 16'h0000));
    end

    // Receive buffer: completed bytes, or the short frame's seven bits.
    always_ff @(posedge clk) begin
        if (end_in && is_short) begin
            mem[0] <= {1'b0, sh[7:1]};
        end else if (take && (cnt != '0) && (bit_idx == 4'd8) &&
                     (byte_idx < NW'(DEPTH))) begin
            mem[byte_idx[AW-1:0]] <= sh;
        end
    end

    // Bit framing: count bits, assemble bytes, note parity faults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            bit_idx  <= '0;
            byte_idx <= '0;
            sh       <= '0;
            par_bad  <= 1'b0;
        end else if (end_in) begin
            cnt <= '0;
        end else if (take) begin
            if (cnt != '1) begin
                cnt <= cnt + CW'(1);
            end
            if (cnt == '0) begin
                bit_idx  <= '0;
                byte_idx <= '0;
                sh       <= '0;
                par_bad  <= 1'b0;
            end else if (bit_idx < 4'd8) begin
                sh      <= {bit_in, sh[7:1]};
                bit_idx <= bit_idx + 4'd1;
            end else begin
                if (^{sh, bit_in} == 1'b0) begin
                    par_bad <= 1'b1;
                end
                if (byte_idx < NW'(DEPTH)) begin
                    byte_idx <= byte_idx + NW'(1);
                end
                bit_idx <= '0;
            end
        end
    end

    // Result registers, updated once per frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            parity_err <= 1'b0;
            crc_err    <= 1'b0;
            length_err <= 1'b0;
            nbytes     <= '0;
        end else begin
            done <= end_in;
            if (end_in) begin
                parity_err <= par_bad && !is_short;
                crc_err    <= crc_bad;
                length_err <= !len_ok;
                nbytes     <= is_short ? NW'(1) : byte_idx;
            end
        end
    end

    // Combinational buffer read port.
    always_comb begin
        rd_data = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : 8'h00;
    end

    p_rx_bit_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= 4'd8);

    p_rx_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nbytes <= NW'(DEPTH));

    p_crc_needs_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(crc_err && length_err));

    p_rx_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_flags_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !end_in |=> $stable({parity_err, crc_err, length_err, nbytes}));

endmodule

// File: rtl/prox_frame_codec.sv
// Proximity link frame codec top: a transmit serializer and a receive
// deserializer sharing one bit-enable strike.
// Assumes: rx_end is not raised in a cycle where a bit is accepted.
module prox_frame_codec #(
    parameter int MAX_DATA = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_stb,
    input  logic        tx_wr_en,
    input  logic [$clog2(MAX_DATA+2)-1:0] tx_wr_addr,
    input  logic [7:0]  tx_wr_data,
    input  logic        tx_start,
    input  logic [$clog2(MAX_DATA+3)-1:0] tx_nbytes,
    input  logic        tx_crc_on,
    input  logic        tx_short,
    output logic        tx_bit,
    output logic        tx_active,
    output logic        tx_done,
    input  logic        rx_bit,
    input  logic        rx_valid,
    input  logic        rx_end,
    input  logic        rx_crc_on,
    input  logic [$clog2(MAX_DATA+2)-1:0] rx_rd_addr,
    output logic [7:0]  rx_rd_data,
    output logic [$clog2(MAX_DATA+3)-1:0] rx_nbytes,
    output logic        rx_done,
    output logic        parity_err,
    output logic        crc_err,
    output logic        length_err
);

    prox_tx_serializer #(.MAX_DATA(MAX_DATA)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .wr_en      (tx_wr_en),
        .wr_addr    (tx_wr_addr),
        .wr_data    (tx_wr_data),
        .start      (tx_start),
        .nbytes     (tx_nbytes),
        .crc_on     (tx_crc_on),
        .short_mode (tx_short),
        .tx_bit     (tx_bit),
        .active     (tx_active),
        .done       (tx_done)
    );

    prox_rx_deserializer #(.MAX_DATA(MAX_DATA)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb        (bit_stb && rx_valid),
        .bit_in     (rx_bit),
        .end_in     (rx_end),
        .crc_on     (rx_crc_on),
        .rd_addr    (rx_rd_addr),
        .rd_data    (rx_rd_data),
        .nbytes     (rx_nbytes),
        .done       (rx_done),
        .parity_err (parity_err),
        .crc_err    (crc_err),
        .length_err (length_err)
    );

endmodule

// File: tb/prox_frame_codec_tb.sv
// Self-checking bench: seeded random frames plus directed corner cases.
module prox_frame_codec_tb;

    localparam int MAX_DATA = 16;
    localparam int DEPTH    = MAX_DATA + 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0;
    logic       tx_wr_en = 1'b0;
    logic [4:0] tx_wr_addr = '0;
    logic [7:0] tx_wr_data = '0;
    logic       tx_start = 1'b0;
    logic [4:0] tx_nbytes = '0;
    logic       tx_crc_on = 1'b0;
    logic       tx_short = 1'b0;
    logic       tx_bit, tx_active, tx_done;
    logic       rx_bit = 1'b0;
    logic       rx_valid = 1'b0;
    logic       rx_end = 1'b0;
    logic       rx_crc_on = 1'b0;
    logic [4:0] rx_rd_addr = '0;
    logic [7:0] rx_rd_data;
    logic [4:0] rx_nbytes;
    logic       rx_done, parity_err, crc_err, length_err;

    prox_frame_codec #(.MAX_DATA(MAX_DATA)) u_dut (.*);

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] data [32];
    logic [7:0] rx_exp [40];
    bit         exp_bits [256];
    int         exp_n;
    int         exp_nb;

    // Record one check and report a failure line.
    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Reference CRC over data[0..n-1], bit-serial, LSB first.
    function automatic logic [15:0] crc_ref(input int n);
        logic [15:0] c = 16'h6363;
        for (int k = 0; k < n; k++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ data[k][b];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    // Build the expected bit stream and byte image for a frame.
    task automatic build(input int n, input bit crc, input bit shrt);
        logic [7:0] bytes [40];
        logic [15:0] c;
        int m;
        exp_n = 0;
        exp_bits[exp_n++] = 1'b1;
        if (shrt) begin
            for (int b = 0; b < 7; b++) exp_bits[exp_n++] = data[0][b];
            rx_exp[0] = {1'b0, data[0][6:0]};
            exp_nb = 1;
            return;
        end
        for (int k = 0; k < n; k++) bytes[k] = data[k];
        m = n;
        if (crc) begin
            c = crc_ref(n);
            bytes[n] = c[7:0];
            bytes[n+1] = c[15:8];
            m = n + 2;
        end
        for (int k = 0; k < m; k++) begin
            for (int b = 0; b < 8; b++) exp_bits[exp_n++] = bytes[k][b];
            exp_bits[exp_n++] = ~^bytes[k];
            rx_exp[k] = bytes[k];
        end
        exp_nb = m;
    endtask

    // Copy the bench data image into the transmit buffer.
    task automatic load_buf();
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            tx_wr_en = 1'b1;
            tx_wr_addr = 5'(k);
            tx_wr_data = data[k];
        end
        @(negedge clk);
        tx_wr_en = 1'b0;
    endtask

    // Send a frame and compare the stream, done pulse and idle state.
    task automatic run_tx(input int len, input bit crc, input bit shrt, input bit poke, input string req);
        int bad_at = -1;
        @(negedge clk);
        tx_nbytes = 5'(len); tx_crc_on = crc; tx_short = shrt; tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        chk(tx_active == 1'b1, "R2 active after start", tx_active, 1);
        for (int i = 0; i < exp_n; i++) begin
            if (tx_bit !== exp_bits[i] && bad_at < 0) bad_at = i;
            bit_stb = 1'b1;
            tx_start = (poke && i == exp_n / 2);
            @(negedge clk);
        end
        bit_stb = 1'b0; tx_start = 1'b0;
        chk(bad_at < 0, {req, " stream"}, bad_at, -1);
        chk(tx_done == 1'b1 && tx_active == 1'b0, "R6 done after last strike", {tx_done, tx_active}, 2);
        @(negedge clk);
        chk(tx_done == 1'b0 && tx_active == 1'b0, "R6 done one cycle", {tx_done, tx_active}, 0);
    endtask

    // Feed exp_bits[0..nbits-1] to the receiver and check its verdict.
    task automatic run_rx(input int nbits, input bit crc, input bit ep, input bit ec, input bit el,
                          input int enb, input string req);
        int bad_at = -1;
        rx_crc_on = crc;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            bit_stb = 1'b1; rx_valid = 1'b1; rx_bit = exp_bits[i];
        end
        @(negedge clk);
        bit_stb = 1'b0; rx_valid = 1'b0; rx_end = 1'b1;
        @(negedge clk);
        rx_end = 1'b0;
        chk(rx_done == 1'b1, {req, " done"}, rx_done, 1);
        chk(parity_err == ep, {req, " parity_err"}, parity_err, ep);
        chk(crc_err == ec, {req, " crc_err"}, crc_err, ec);
        chk(length_err == el, {req, " length_err"}, length_err, el);
        chk(int'(rx_nbytes) == enb, {req, " nbytes"}, rx_nbytes, enb);
        if (!ep && !ec && !el) begin
            for (int k = 0; k < enb; k++) begin
                rx_rd_addr = 5'(k);
                #1;
                if (rx_rd_data !== rx_exp[k] && bad_at < 0) bad_at = k;
            end
            chk(bad_at < 0, {req, " bytes"}, bad_at, -1);
        end
        @(negedge clk);
        chk(rx_done == 1'b0, "R12 rx_done one cycle", rx_done, 0);
    endtask

    function automatic int eff_len(input int len, input bit crc);
        int cap = crc ? MAX_DATA : DEPTH;
        if (len == 0) return 1;
        return (len > cap) ? cap : len;
    endfunction

    // Watchdog: an expired run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({tx_active, tx_bit, tx_done} == 3'b000, "R1 tx idle", {tx_active, tx_bit, tx_done}, 0);
        chk({rx_done, parity_err, crc_err, length_err} == 4'b0 && rx_nbytes == 0, "R1 rx idle",
            {rx_done, parity_err, crc_err, length_err}, 0);

        // R4: known CRC pair 0x50 0x00 -> 0x57 0xCD, plus loopback
        for (int k = 0; k < 32; k++) data[k] = 8'($urandom);
        data[0] = 8'h50; data[1] = 8'h00;
        load_buf();
        data[2] = 8'h57; data[3] = 8'hCD;
        build(4, 1'b0, 1'b0);
        run_tx(2, 1'b1, 1'b0, 1'b0, "R4 known crc");
        run_rx(exp_n, 1'b1, 0, 0, 0, 4, "R8 known crc loopback");

        // R6: tx_start mid-frame ignored; R3 parity on a 5-byte frame
        for (int k = 0; k < 32; k++) data[k] = 8'($urandom);
        load_buf();
        build(5, 1'b0, 1'b0);
        run_tx(5, 1'b0, 1'b0, 1'b1, "R6 R3 start ignored");
        repeat (3) @(negedge clk);
        chk(tx_active == 1'b0, "R6 no restart", tx_active, 0);

        // R7: clamp cases
        build(16, 1'b1, 1'b0);
        run_tx(20, 1'b1, 1'b0, 1'b0, "R7 clamp 16 with crc");
        build(1, 1'b0, 1'b0);
        run_tx(0, 1'b0, 1'b0, 1'b0, "R7 zero means one");
        build(18, 1'b0, 1'b0);
        run_tx(25, 1'b0, 1'b0, 1'b0, "R7 clamp 18 no crc");
        run_rx(exp_n, 1'b0, 0, 0, 0, 18, "R10 exact 163 bits");

        // R5: short frame both ways (crc requested but not applied)
        build(1, 1'b0, 1'b1);
        run_tx(3, 1'b1, 1'b1, 1'b0, "R5 short tx");
        run_rx(exp_n, 1'b1, 0, 0, 0, 1, "R5 R10 short rx");

        // R9: bad parity on byte 1
        build(3, 1'b1, 1'b0);
        exp_bits[1 + 9 + 8] = ~exp_bits[1 + 9 + 8];
        run_rx(exp_n, 1'b1, 1, 0, 0, 5, "R9 parity");

        // R11: data bit and its parity flipped
        build(3, 1'b1, 1'b0);
        exp_bits[1 + 3] = ~exp_bits[1 + 3];
        exp_bits[1 + 8] = ~exp_bits[1 + 8];
        run_rx(exp_n, 1'b1, 0, 1, 0, 5, "R11 crc mismatch");

        // R11: too few bytes for a CRC
        build(2, 1'b0, 1'b0);
        run_rx(exp_n, 1'b1, 0, 1, 0, 2, "R11 under three bytes");

        // R10: one bit short, then hold check for R12
        build(3, 1'b1, 1'b0);
        run_rx(exp_n - 1, 1'b1, 0, 0, 1, 4, "R10 missing bit");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            bit_stb = 1'($urandom);
        end
        @(negedge clk);
        bit_stb = 1'b0;
        chk({rx_done, length_err, crc_err} == 3'b010 && rx_nbytes == 4, "R12 flags held",
            {rx_done, length_err, crc_err}, 3'b010);

        // R10: start bit only, and an over-long frame
        run_rx(1, 1'b0, 0, 0, 1, 0, "R10 start only");
        build(19, 1'b0, 1'b0);
        run_rx(exp_n, 1'b0, 0, 0, 1, 18, "R10 over 163 bits");

        // R2 R3 R4 R8: seeded random loopback frames
        for (int it = 0; it < 40; it++) begin
            int len;
            bit crc, shrt;
            int e;
            for (int k = 0; k < 32; k++) data[k] = 8'($urandom);
            len  = int'($urandom_range(0, 22));
            crc  = 1'($urandom);
            shrt = ($urandom_range(0, 5) == 0);
            load_buf();
            e = eff_len(len, crc);
            if (shrt) build(1, 1'b0, 1'b1);
            else build(e, crc, 1'b0);
            run_tx(len, crc, shrt, 1'b0, "R2 R3 R4 random tx");
            run_rx(exp_n, crc, 0, 0, 0, exp_nb, "R8 random loopback");
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule